// File: doc/BRIEF.md
# Timer Input Pin Mode Controller

This block is a 16-bit up/down timer whose two external pins, A and B, are given their roles by a 3-bit mode selector. A pin can be left as plain I/O, which the timer ignores. It can act as a gate that qualifies counting. Pin B can act as an external clock source for the prescaler. Either pin can be a trigger that starts a reload or a capture on its own 16-bit register. Pin A always serves the first register (REG0) and pin B always serves the second (REG1). Count direction never comes from the pins. A single software bit sets it.

Both pins are synchronized on entry. The prescaler divides the qualified source events, and each prescaler tick is one count enable for the counter. A small write port loads REG0, REG1 or the counter directly. Each register has a control input that chooses capture or reload.

Top module: `tpm_top`

## Requirements
- R1: The `mode_i` encoding sets the pin roles (A/B) as follows: 0 = io/io, 1 = io/trigger, 2 = gate/io, 3 = gate/trigger, 4 = io/extclock, 5 = trigger/io, 6 = gate/extclock, 7 = trigger/trigger.
- R2: Each pin passes through two synchronizing flops, and triggers and the external clock act on a synchronized rising edge. A pin that rises before clock edge k has its effect at edge k+2.
- R3: Count direction depends only on `up_i` (1 = up, 0 = down). The counter wraps modulo 2^16 in both directions.
- R4: In the gate modes (2, 3, 6), the counter advances only while the synchronized level of pin A is low.
- R5: In the external clock modes (4, 6), each synchronized rising edge of pin B is one source event. In every other mode, every clock cycle is one source event.
- R6: In mode 6, pin B edges reach the prescaler only while pin A is low.
- R7: The prescaler issues one count enable for every `presc_i`+1 qualified source events.
- R8: A trigger on pin A acts on REG0, and a trigger on pin B acts on REG1. In mode 7 the two pins act independently. A trigger pin also acts while the other pin is a gate (mode 3).
- R9: In capture mode (`capN_i`=1), a trigger stores the counter value into its register at the trigger edge. If a software write to the same register falls on that same edge, the capture wins.
- R10: In reload mode (`capN_i`=0), a trigger makes a reload pending. On the next count enable the counter loads that register's value, and the pending request clears. If both registers are pending, REG0 is used and both requests clear.
- R11: A pin in the I/O role has no effect on the counter or on either register.
- R12: While `run_i`=0, no count enable occurs. A write with `wr_sel_i`=0, 1 or 2 loads REG0, REG1 or the counter respectively. A counter write takes precedence over a count enable on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Pin role selector |
| up_i | input | 1 | Software count direction, 1 = up |
| run_i | input | 1 | Timer run enable |
| presc_i | input | 8 | Prescaler divide value minus one |
| cap0_i | input | 1 | REG0 action: 1 capture, 0 reload |
| cap1_i | input | 1 | REG1 action: 1 capture, 0 reload |
| pin_a_i | input | 1 | External pin A (asynchronous) |
| pin_b_i | input | 1 | External pin B (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 REG0, 1 REG1, 2 counter |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Counter value |
| reg0_o | output | 16 | REG0 value |
| reg1_o | output | 16 | REG1 value |

## Verification
Two pairs of events can land on the same edge. The first pair is a capture and a software write to the same register. The bench raises pin A and then strobes a REG0 write timed so that it is sampled on exactly the capture edge; it expects REG0 to hold the counter value rather than the write data. The second pair is a pending reload and a count enable. The bench triggers REG0 and REG1 reloads together while the timer is stopped. It then runs for single cycles and expects REG0's value first, followed by a plain increment.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef enum logic [2:0] {
    MODE_IO_IO    = 3'd0,
    MODE_IO_TRG   = 3'd1,
    MODE_GATE_IO  = 3'd2,
    MODE_GATE_TRG = 3'd3,
    MODE_IO_XCK   = 3'd4,
    MODE_TRG_IO   = 3'd5,
    MODE_GATE_XCK = 3'd6,
    MODE_TRG_TRG  = 3'd7
  } pin_mode_e;

  typedef struct packed {
    logic a_gate;
    logic a_trig;
    logic b_trig;
    logic b_xclk;
  } pin_roles_t;

  localparam logic [1:0] SEL_REG0 = 2'd0;
  localparam logic [1:0] SEL_REG1 = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

endpackage

// File: rtl/tpm_edge_sync.sv
module tpm_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign level_o[g] = s2_q;
    assign rise_o[g]  = s2_q & ~s3_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]); // R2
  end

endmodule

// File: rtl/tpm_role_dec.sv
module tpm_role_dec
  import tpm_pkg::*;
(
  input  logic [2:0] mode_i,
  output pin_roles_t roles_o
);

  always_comb begin
    roles_o = '0;
    unique case (pin_mode_e'(mode_i))
      MODE_IO_IO:    ;
      MODE_IO_TRG:   roles_o.b_trig = 1'b1;
      MODE_GATE_IO:  roles_o.a_gate = 1'b1;
      MODE_GATE_TRG: begin
        roles_o.a_gate = 1'b1;
        roles_o.b_trig = 1'b1;
      end
      MODE_IO_XCK:   roles_o.b_xclk = 1'b1;
      MODE_TRG_IO:   roles_o.a_trig = 1'b1;
      MODE_GATE_XCK: begin
        roles_o.a_gate = 1'b1;
        roles_o.b_xclk = 1'b1;
      end
      MODE_TRG_TRG: begin
        roles_o.a_trig = 1'b1;
        roles_o.b_trig = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tpm_prescaler.sv
module tpm_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_en_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);

  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    tick_o = 1'b0;
    if (src_en_i) begin
      if (pcnt_q >= presc_i) begin
        pcnt_d = '0;
        tick_o = 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> src_en_i); // R7
  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && presc_i != '0 && $stable(presc_i)) |=> !tick_o); // R7

endmodule

// File: rtl/tpm_count_regs.sv
module tpm_count_regs
  import tpm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         up_i,
  input  logic         trig0_i,
  input  logic         trig1_i,
  input  logic         cap0_i,
  input  logic         cap1_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reg0_o,
  output logic [W-1:0] reg1_o
);

  logic [W-1:0] cnt_q, cnt_d, r0_q, r0_d, r1_q, r1_d;
  logic         pend0_q, pend0_d, pend1_q, pend1_d;
  logic         cap0_ev, cap1_ev, rel0_eff, rel1_eff, wr_cnt;

  assign cap0_ev  = trig0_i & cap0_i;
  assign cap1_ev  = trig1_i & cap1_i;
  assign rel0_eff = pend0_q | (trig0_i & ~cap0_i);
  assign rel1_eff = pend1_q | (trig1_i & ~cap1_i);
  assign wr_cnt   = wr_en_i & (wr_sel_i == SEL_CNT);

  always_comb begin
    cnt_d   = cnt_q;
    pend0_d = rel0_eff;
    pend1_d = rel1_eff;
    if (wr_cnt) begin
      cnt_d = wr_data_i;
    end else if (tick_i) begin
      pend0_d = 1'b0;
      pend1_d = 1'b0;
      if (rel0_eff)      cnt_d = r0_q;
      else if (rel1_eff) cnt_d = r1_q;
      else if (up_i)     cnt_d = cnt_q + 1'b1;
      else               cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    r0_d = r0_q;
    r1_d = r1_q;
    if (cap0_ev)                                  r0_d = cnt_q;
    else if (wr_en_i && wr_sel_i == SEL_REG0)     r0_d = wr_data_i;
    if (cap1_ev)                                  r1_d = cnt_q;
    else if (wr_en_i && wr_sel_i == SEL_REG1)     r1_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      r0_q    <= '0;
      r1_q    <= '0;
      pend0_q <= 1'b0;
      pend1_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      r0_q    <= r0_d;
      r1_q    <= r1_d;
      pend0_q <= pend0_d;
      pend1_q <= pend1_d;
    end
  end

  assign count_o = cnt_q;
  assign reg0_o  = r0_q;
  assign reg1_o  = r1_q;

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && up_i && !wr_cnt && !rel0_eff && !rel1_eff)
      |=> count_o == $past(count_o) + 1'b1); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !up_i && !wr_cnt && !rel0_eff && !rel1_eff)
      |=> count_o == $past(count_o) - 1'b1); // R3
  AST_CAPTURE0: assert property (@(posedge clk) disable iff (!rst_n)
    cap0_ev |=> reg0_o == $past(count_o)); // R9
  AST_CAPTURE1: assert property (@(posedge clk) disable iff (!rst_n)
    cap1_ev |=> reg1_o == $past(count_o)); // R9
  AST_RELOAD0: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rel0_eff && !wr_cnt) |=> count_o == $past(reg0_o)); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_cnt) |=> $stable(count_o)); // R12

endmodule

// File: rtl/tpm_top.sv
module tpm_top
  import tpm_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          up_i,
  input  logic          run_i,
  input  logic [PW-1:0] presc_i,
  input  logic          cap0_i,
  input  logic          cap1_i,
  input  logic          pin_a_i,
  input  logic          pin_b_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  count_o,
  output logic [W-1:0]  reg0_o,
  output logic [W-1:0]  reg1_o
);

  localparam int NPIN = 2;

  pin_roles_t      roles;
  logic [NPIN-1:0] lvl, rise;
  logic            gate_ok, src_ev, src_en, cnt_tick, trig0, trig1;

  tpm_edge_sync #(.N(NPIN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   ({pin_b_i, pin_a_i}),
    .level_o (lvl),
    .rise_o  (rise)
  );

  tpm_role_dec u_dec (
    .mode_i  (mode_i),
    .roles_o (roles)
  );

  assign gate_ok = ~roles.a_gate | ~lvl[0];
  assign src_ev  = roles.b_xclk ? rise[1] : 1'b1;
  assign src_en  = run_i & gate_ok & src_ev;
  assign trig0   = roles.a_trig & rise[0];
  assign trig1   = roles.b_trig & rise[1];

  tpm_prescaler #(.PW(PW)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en_i (src_en),
    .presc_i  (presc_i),
    .tick_o   (cnt_tick)
  );

  tpm_count_regs #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (cnt_tick),
    .up_i      (up_i),
    .trig0_i   (trig0),
    .trig1_i   (trig1),
    .cap0_i    (cap0_i),
    .cap1_i    (cap1_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .reg0_o    (reg0_o),
    .reg1_o    (reg1_o)
  );

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (roles.a_gate && lvl[0]) |-> !cnt_tick); // R4
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !cnt_tick); // R12
  AST_IO_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_IO_IO) |-> (!trig0 && !trig1)); // R11
  AST_XCLK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (roles.b_xclk && !rise[1]) |-> !cnt_tick); // R5
  AST_A_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({roles.a_gate, roles.a_trig})); // R1

endmodule

// File: tb/test_tpm_top.sv
`timescale 1ns/1ps
module test_tpm_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        up, run, cap0, cap1, pa, pb, wr_en;
  logic [7:0]  presc;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic [15:0] count, reg0, reg1;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tpm_top i_tpm_top (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .up_i(up), .run_i(run),
    .presc_i(presc), .cap0_i(cap0), .cap1_i(cap1), .pin_a_i(pa), .pin_b_i(pb),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .count_o(count), .reg0_o(reg0), .reg1_o(reg1)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_a();
    pa = 1'b1; cyc(2); pa = 1'b0; cyc(2);
  endtask

  task automatic pulse_b();
    pb = 1'b1; cyc(2); pb = 1'b0; cyc(2);
  endtask

  task automatic step1();
    run = 1'b1; cyc(1); run = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 reset count", count, 16'h0);
    chk("R12 reset reg0", reg0, 16'h0);
    chk("R12 reset reg1", reg1, 16'h0);
  endtask

  task automatic t_io_ignore();
    logic [15:0] c0;
    mode = 3'd0; cap0 = 1; cap1 = 1;
    wr(2'd0, 16'h2222); wr(2'd1, 16'h4444); wr(2'd2, 16'h3333);
    pulse_a(); pulse_b(); cyc(2);
    chk("R11 reg0 untouched", reg0, 16'h2222);
    chk("R11 reg1 untouched", reg1, 16'h4444);
    chk("R12 stopped holds", count, 16'h3333);
    pa = 1; run = 1; cyc(4); c0 = count; cyc(5);
    chk("R11 A high no gate", count, c0 + 16'd5);
    run = 0; pa = 0; cyc(3);
  endtask

  task automatic t_direction();
    wr(2'd2, 16'h0000); up = 0; step1();
    chk("R3 down wrap", count, 16'hFFFF);
    up = 1; step1();
    chk("R3 up wrap", count, 16'h0000);
  endtask

  task automatic t_gate();
    logic [15:0] c0;
    mode = 3'd2; run = 1; pa = 1; cyc(4); c0 = count; cyc(5);
    chk("R4 gated holds", count, c0);
    pa = 0; cyc(4); c0 = count; up = 0; cyc(5);
    chk("R4 open counts down", count, c0 - 16'd5);
    up = 1; run = 0; cyc(2);
  endtask

  task automatic t_extclk();
    logic [15:0] c0;
    mode = 3'd4; run = 1; cyc(4); c0 = count;
    pulse_b(); pulse_b(); pulse_b(); cyc(4);
    chk("R5 three B edges", count, c0 + 16'd3);
    mode = 3'd6; pa = 1; cyc(4); c0 = count;
    pulse_b(); pulse_b(); cyc(4);
    chk("R6 gate blocks ext clock", count, c0);
    pa = 0; cyc(4); c0 = count;
    pulse_b(); pulse_b(); cyc(4);
    chk("R6 gate open ext clock", count, c0 + 16'd2);
    run = 0; cyc(2);
  endtask

  task automatic t_presc();
    logic [15:0] c0;
    mode = 3'd0; presc = 8'd2; run = 1; cyc(3); c0 = count; cyc(12);
    chk("R7 divide by 3", count, c0 + 16'd4);
    run = 0; presc = 8'd0; cyc(2);
  endtask

  task automatic t_capture_latency();
    mode = 3'd5; cap0 = 1;
    wr(2'd0, 16'h1111); wr(2'd2, 16'hBEEF);
    pa = 1; cyc(1);
    chk("R2 edge k no capture", reg0, 16'h1111);
    cyc(1);
    chk("R2 edge k+1 no capture", reg0, 16'h1111);
    cyc(1);
    chk("R2 R9 capture at k+2", reg0, 16'hBEEF);
    pa = 0; cyc(3);
  endtask

  task automatic t_capture_vs_write();
    mode = 3'd5; cap0 = 1; wr(2'd2, 16'h5A5A);
    pa = 1; cyc(2);
    wr(2'd0, 16'h0F0F);
    chk("R9 capture beats write", reg0, 16'h5A5A);
    pa = 0; cyc(3);
    wr(2'd0, 16'h0F0F);
    chk("R12 plain write reg0", reg0, 16'h0F0F);
  endtask

  task automatic t_routing();
    mode = 3'd1; cap0 = 1; cap1 = 1;
    wr(2'd0, 16'hAAAA); wr(2'd1, 16'hBBBB); wr(2'd2, 16'h1234);
    pulse_a(); cyc(2);
    chk("R1 mode1 A is io", reg0, 16'hAAAA);
    pulse_b(); cyc(2);
    chk("R8 mode1 B to REG1", reg1, 16'h1234);
    mode = 3'd3; run = 1; pa = 1; cyc(4);
    wr(2'd2, 16'h7777); cyc(2);
    pulse_b(); cyc(2);
    chk("R8 mode3 gated trigger", reg1, 16'h7777);
    chk("R4 mode3 still gated", count, 16'h7777);
    run = 0; pa = 0; cyc(3);
    mode = 3'd7; wr(2'd2, 16'h4321);
    pulse_a(); cyc(2);
    chk("R8 mode7 A to REG0", reg0, 16'h4321);
    chk("R8 mode7 REG1 kept", reg1, 16'h7777);
  endtask

  task automatic t_reload();
    mode = 3'd7; cap0 = 0; cap1 = 0;
    wr(2'd0, 16'h0A0A); wr(2'd1, 16'h0B0B); wr(2'd2, 16'h0000);
    pa = 1; pb = 1; cyc(2); pa = 0; pb = 0; cyc(3);
    chk("R10 pending no enable", count, 16'h0000);
    step1();
    chk("R10 REG0 priority", count, 16'h0A0A);
    step1();
    chk("R10 both cleared", count, 16'h0A0B);
    pulse_b(); cyc(2); step1();
    chk("R10 REG1 reload", count, 16'h0B0B);
    run = 1; wr(2'd2, 16'h6000);
    chk("R12 write beats tick", count, 16'h6000);
    cyc(1); run = 0;
    chk("R12 counts after write", count, 16'h6001);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; mode = 0; up = 1; run = 0; cap0 = 0; cap1 = 0;
    pa = 0; pb = 0; wr_en = 0; wr_sel = 0; wr_data = 0; presc = 0;
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_io_ignore();
    t_direction();
    t_gate();
    t_extclk();
    t_presc();
    t_capture_latency();
    t_capture_vs_write();
    t_routing();
    t_reload();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule